// File: doc/BRIEF.md
# Operand Effective Address Generator

This block forms the data-memory addresses for the two operands of a move-type instruction on a 16-bit datapath with sixteen working registers. The decoder gives it an addressing-mode code, a pointer register number for the source and the destination, a single index-register number that both operands share, an explicit file address, a short signed literal, and the contents of the register file as one flat vector. One cycle later the block returns an effective address and a memory-access flag for each operand. It also returns writeback requests for pointers that are modified before or after use.

The two operands pick their modes on their own, so one instruction can read through a post-incremented pointer and write through an indexed one. Both operands modify a pointer on some instructions. When both modify the same pointer, only the destination's update reaches the register file, and a conflict flag is raised. Decoding, memory access and circular-buffer wrapping are done outside this block.

Top module: `operand_ea_gen`

## Requirements
- R1: Mode code 0 (file direct) gives an EA equal to the explicit file-address input, with the memory flag set and no writeback.
- R2: Mode code 1 (register direct) performs no memory access: the memory flag, the EA and the writeback request are all zero.
- R3: Mode code 2 (indirect) gives an EA equal to the pointer register's contents, with no writeback.
- R4: Mode codes 3 (post-increment) and 4 (post-decrement) give an EA equal to the unmodified pointer, and request a writeback of the pointer plus or minus the step to that register.
- R5: Mode codes 5 (pre-increment) and 6 (pre-decrement) give an EA equal to the pointer plus or minus the step, and write that same value back to the pointer.
- R6: The step is 1 when the byte-operation input is 1 and 2 when it is 0, and applies to both operands.
- R7: Mode code 7 (indexed) gives an EA equal to the pointer plus the register named by the single shared index field, which both operands use.
- R8: Mode code 8 (literal offset) gives an EA equal to the pointer plus the 10-bit literal sign-extended to 16 bits. All address arithmetic wraps modulo 2^16.
- R9: The source and destination modes are decoded independently within one instruction.
- R10: When both operands request a writeback to the same register, the source request is dropped, the destination request is kept, and the conflict output is 1. Otherwise the conflict output is 0.
- R11: Outputs appear one clock after an input cycle with the valid input high. After a cycle with the valid input low, and during reset, every output is zero.
- R12: Mode codes 9 to 15 are reserved: they give a zero EA, no memory access and no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Operand fields are valid this cycle |
| byte_op_i | input | 1 | 1: step of 1, 0: step of 2 |
| src_mode_i | input | 4 | Source addressing-mode code |
| src_reg_i | input | 4 | Source pointer register number |
| dst_mode_i | input | 4 | Destination addressing-mode code |
| dst_reg_i | input | 4 | Destination pointer register number |
| idx_reg_i | input | 4 | Shared index register number |
| faddr_i | input | 16 | Explicit file address |
| lit_i | input | 10 | Signed literal offset |
| regs_i | input | 256 | Register file, register k at bits [16k+15:16k] |
| out_valid_o | output | 1 | Results valid |
| src_ea_o | output | 16 | Source EA |
| src_mem_o | output | 1 | Source accesses memory |
| dst_ea_o | output | 16 | Destination EA |
| dst_mem_o | output | 1 | Destination accesses memory |
| src_wb_en_o | output | 1 | Source pointer writeback request |
| src_wb_reg_o | output | 4 | Source writeback register |
| src_wb_data_o | output | 16 | Source writeback value |
| dst_wb_en_o | output | 1 | Destination pointer writeback request |
| dst_wb_reg_o | output | 4 | Destination writeback register |
| dst_wb_data_o | output | 16 | Destination writeback value |
| conflict_o | output | 1 | Both operands modified the same register |

## Verification
The register file is loaded so that each register holds its number times 0x1111, which makes every sum easy to tell apart. The top register holds 0xFFFF, so offsets and increments on it cross the 16-bit wrap. The vector table pairs a different source mode with a different destination mode in each row, so a swapped or shared decode shows up as a wrong address on one side. Literals of both signs separate sign extension from zero extension, and byte and word steps separate the step choice. Directed cases cover a same-register modify pair, which exposes the wrong winner in a conflict. They also cover a non-modifying source on the register that the destination modifies, which exposes a false conflict. The reserved codes and an idle cycle are checked as well.

// File: rtl/eag_pkg.sv
package eag_pkg;
   localparam logic [3:0] AM_FILE    = 4'd0;
   localparam logic [3:0] AM_REGDIR  = 4'd1;
   localparam logic [3:0] AM_IND     = 4'd2;
   localparam logic [3:0] AM_POSTINC = 4'd3;
   localparam logic [3:0] AM_POSTDEC = 4'd4;
   localparam logic [3:0] AM_PREINC  = 4'd5;
   localparam logic [3:0] AM_PREDEC  = 4'd6;
   localparam logic [3:0] AM_INDEX   = 4'd7;
   localparam logic [3:0] AM_LITOFS  = 4'd8;

   function automatic logic am_is_modify(input logic [3:0] m);
      return (m >= AM_POSTINC) && (m <= AM_PREDEC);
   endfunction
endpackage

// File: rtl/eag_regsel.sv
module eag_regsel #(
   parameter int DW   = 16,
   parameter int NREG = 16,
   localparam int RW  = $clog2(NREG)
) (
   input  logic [NREG*DW-1:0] regs_i,
   input  logic [RW-1:0]      sel_i,
   output logic [DW-1:0]      data_o
);
   logic [DW-1:0] bank [NREG];

   for (genvar k = 0; k < NREG; k++) begin : g_unpack
      assign bank[k] = regs_i[k*DW +: DW];
   end

   assign data_o = bank[sel_i];
endmodule

// File: rtl/eag_unit.sv
module eag_unit
   import eag_pkg::*;
#(
   parameter int DW    = 16,
   parameter int LIT_W = 10
) (
   input  logic [3:0]       mode_i,
   input  logic             byte_op_i,
   input  logic [DW-1:0]    ptr_i,
   input  logic [DW-1:0]    idx_i,
   input  logic [DW-1:0]    faddr_i,
   input  logic [LIT_W-1:0] lit_i,
   output logic [DW-1:0]    ea_o,
   output logic             mem_o,
   output logic             wb_en_o,
   output logic [DW-1:0]    wb_data_o
);
   logic [DW-1:0] step, up, down, lit_ext;

   assign step    = byte_op_i ? DW'(1) : DW'(2);
   assign up      = ptr_i + step;
   assign down    = ptr_i - step;
   assign lit_ext = DW'($signed(lit_i));

   always_comb begin
      ea_o      = '0;
      mem_o     = 1'b0;
      wb_en_o   = 1'b0;
      wb_data_o = '0;
      case (mode_i)
         AM_FILE: begin
            ea_o  = faddr_i;
            mem_o = 1'b1;
         end
         AM_IND: begin
            ea_o  = ptr_i;
            mem_o = 1'b1;
         end
         AM_POSTINC: begin
            ea_o = ptr_i; mem_o = 1'b1; wb_en_o = 1'b1; wb_data_o = up;
         end
         AM_POSTDEC: begin
            ea_o = ptr_i; mem_o = 1'b1; wb_en_o = 1'b1; wb_data_o = down;
         end
         AM_PREINC: begin
            ea_o = up; mem_o = 1'b1; wb_en_o = 1'b1; wb_data_o = up;
         end
         AM_PREDEC: begin
            ea_o = down; mem_o = 1'b1; wb_en_o = 1'b1; wb_data_o = down;
         end
         AM_INDEX: begin
            ea_o  = ptr_i + idx_i;
            mem_o = 1'b1;
         end
         AM_LITOFS: begin
            ea_o  = ptr_i + lit_ext;
            mem_o = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/eag_wb_arb.sv
module eag_wb_arb #(
   parameter int RW = 4
) (
   input  logic          src_req_i,
   input  logic [RW-1:0] src_reg_i,
   input  logic          dst_req_i,
   input  logic [RW-1:0] dst_reg_i,
   output logic          src_grant_o,
   output logic          dst_grant_o,
   output logic          conflict_o
);
   assign conflict_o  = src_req_i && dst_req_i && (src_reg_i == dst_reg_i);
   assign src_grant_o = src_req_i && !conflict_o;
   assign dst_grant_o = dst_req_i;
endmodule

// File: rtl/operand_ea_gen.sv
module operand_ea_gen
   import eag_pkg::*;
#(
   parameter int DW      = 16,
   parameter int NREG    = 16,
   parameter int LIT_W   = 10,
   parameter bit REG_OUT = 1'b1,
   localparam int RW     = $clog2(NREG)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               in_valid_i,
   input  logic               byte_op_i,
   input  logic [3:0]         src_mode_i,
   input  logic [RW-1:0]      src_reg_i,
   input  logic [3:0]         dst_mode_i,
   input  logic [RW-1:0]      dst_reg_i,
   input  logic [RW-1:0]      idx_reg_i,
   input  logic [DW-1:0]      faddr_i,
   input  logic [LIT_W-1:0]   lit_i,
   input  logic [NREG*DW-1:0] regs_i,
   output logic               out_valid_o,
   output logic [DW-1:0]      src_ea_o,
   output logic               src_mem_o,
   output logic [DW-1:0]      dst_ea_o,
   output logic               dst_mem_o,
   output logic               src_wb_en_o,
   output logic [RW-1:0]      src_wb_reg_o,
   output logic [DW-1:0]      src_wb_data_o,
   output logic               dst_wb_en_o,
   output logic [RW-1:0]      dst_wb_reg_o,
   output logic [DW-1:0]      dst_wb_data_o,
   output logic               conflict_o
);
   if (DW < 8)                   begin : g_bad_dw   $error("DW must be at least 8");            end
   if ((1 << RW) != NREG)        begin : g_bad_nreg $error("NREG must be a power of two");      end
   if (LIT_W < 2 || LIT_W > DW)  begin : g_bad_lit  $error("LIT_W must lie in 2..DW");          end

   localparam int NOP = 2;   // operand 0 = source, 1 = destination

   logic [3:0]    op_mode [NOP];
   logic [RW-1:0] op_reg  [NOP];
   logic [DW-1:0] op_ptr  [NOP];
   logic [DW-1:0] op_ea   [NOP];
   logic          op_mem  [NOP];
   logic          op_wb   [NOP];
   logic [DW-1:0] op_wbd  [NOP];
   logic [DW-1:0] idx_val;

   assign op_mode[0] = src_mode_i;
   assign op_mode[1] = dst_mode_i;
   assign op_reg[0]  = src_reg_i;
   assign op_reg[1]  = dst_reg_i;

   eag_regsel #(.DW(DW), .NREG(NREG)) u_idx_sel (
      .regs_i(regs_i), .sel_i(idx_reg_i), .data_o(idx_val)
   );

   for (genvar k = 0; k < NOP; k++) begin : g_op
      eag_regsel #(.DW(DW), .NREG(NREG)) u_sel (
         .regs_i(regs_i), .sel_i(op_reg[k]), .data_o(op_ptr[k])
      );
      eag_unit #(.DW(DW), .LIT_W(LIT_W)) u_unit (
         .mode_i(op_mode[k]), .byte_op_i(byte_op_i), .ptr_i(op_ptr[k]),
         .idx_i(idx_val), .faddr_i(faddr_i), .lit_i(lit_i),
         .ea_o(op_ea[k]), .mem_o(op_mem[k]), .wb_en_o(op_wb[k]), .wb_data_o(op_wbd[k])
      );
   end

   logic src_grant, dst_grant, clash;

   eag_wb_arb #(.RW(RW)) u_arb (
      .src_req_i(op_wb[0]), .src_reg_i(src_reg_i),
      .dst_req_i(op_wb[1]), .dst_reg_i(dst_reg_i),
      .src_grant_o(src_grant), .dst_grant_o(dst_grant), .conflict_o(clash)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i) begin
         if (!rst_ni || !in_valid_i) begin
            out_valid_o   <= 1'b0;
            src_ea_o      <= '0;
            src_mem_o     <= 1'b0;
            dst_ea_o      <= '0;
            dst_mem_o     <= 1'b0;
            src_wb_en_o   <= 1'b0;
            src_wb_reg_o  <= '0;
            src_wb_data_o <= '0;
            dst_wb_en_o   <= 1'b0;
            dst_wb_reg_o  <= '0;
            dst_wb_data_o <= '0;
            conflict_o    <= 1'b0;
         end else begin
            out_valid_o   <= 1'b1;
            src_ea_o      <= op_ea[0];
            src_mem_o     <= op_mem[0];
            dst_ea_o      <= op_ea[1];
            dst_mem_o     <= op_mem[1];
            src_wb_en_o   <= src_grant;
            src_wb_reg_o  <= src_grant ? src_reg_i : '0;
            src_wb_data_o <= src_grant ? op_wbd[0] : '0;
            dst_wb_en_o   <= dst_grant;
            dst_wb_reg_o  <= dst_grant ? dst_reg_i : '0;
            dst_wb_data_o <= dst_grant ? op_wbd[1] : '0;
            conflict_o    <= clash;
         end
      end

      // R2: register direct on the destination never touches memory
      a_r2_regdir_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
         in_valid_i && dst_mode_i == AM_REGDIR |=> !dst_mem_o && !dst_wb_en_o && dst_ea_o == '0);
      // R4: post-increment writes back EA plus step
      a_r4_post_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
         in_valid_i && dst_mode_i == AM_POSTINC |=>
            dst_wb_en_o && dst_wb_data_o == dst_ea_o + ($past(byte_op_i) ? DW'(1) : DW'(2)));
      // R5: pre-modify writes back exactly the EA used
      a_r5_pre_same: assert property (@(posedge clk_i) disable iff (!rst_ni)
         in_valid_i && (dst_mode_i == AM_PREINC || dst_mode_i == AM_PREDEC) |=>
            dst_wb_en_o && dst_wb_data_o == dst_ea_o);
      // R10: a conflict keeps only the destination update
      a_r10_dst_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
         conflict_o |-> dst_wb_en_o && !src_wb_en_o);
      // R10: two granted writes never target one register
      a_r10_distinct: assert property (@(posedge clk_i) disable iff (!rst_ni)
         src_wb_en_o && dst_wb_en_o |-> src_wb_reg_o != dst_wb_reg_o);
      // R11: an idle cycle yields quiet outputs
      a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !in_valid_i |=> !out_valid_o && !src_mem_o && !dst_mem_o &&
                         !src_wb_en_o && !dst_wb_en_o && !conflict_o);
   end else begin : g_comb
      always_comb begin
         out_valid_o   = in_valid_i;
         src_ea_o      = in_valid_i ? op_ea[0] : '0;
         src_mem_o     = in_valid_i && op_mem[0];
         dst_ea_o      = in_valid_i ? op_ea[1] : '0;
         dst_mem_o     = in_valid_i && op_mem[1];
         src_wb_en_o   = in_valid_i && src_grant;
         src_wb_reg_o  = src_wb_en_o ? src_reg_i : '0;
         src_wb_data_o = src_wb_en_o ? op_wbd[0] : '0;
         dst_wb_en_o   = in_valid_i && dst_grant;
         dst_wb_reg_o  = dst_wb_en_o ? dst_reg_i : '0;
         dst_wb_data_o = dst_wb_en_o ? op_wbd[1] : '0;
         conflict_o    = in_valid_i && clash;
      end
   end
endmodule

// File: tb/sim_operand_ea_gen.sv
module sim_operand_ea_gen;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0, byte_op = 1'b0;
   logic [3:0]   src_mode = '0, src_reg = '0, dst_mode = '0, dst_reg = '0, idx_reg = '0;
   logic [15:0]  faddr = '0;
   logic [9:0]   lit = '0;
   logic [255:0] regs;
   logic         out_valid, src_mem, dst_mem, src_wb_en, dst_wb_en, conflict;
   logic [15:0]  src_ea, dst_ea, src_wb_data, dst_wb_data;
   logic [3:0]   src_wb_reg, dst_wb_reg;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   operand_ea_gen u0 (
      .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .byte_op_i(byte_op),
      .src_mode_i(src_mode), .src_reg_i(src_reg), .dst_mode_i(dst_mode), .dst_reg_i(dst_reg),
      .idx_reg_i(idx_reg), .faddr_i(faddr), .lit_i(lit), .regs_i(regs),
      .out_valid_o(out_valid), .src_ea_o(src_ea), .src_mem_o(src_mem),
      .dst_ea_o(dst_ea), .dst_mem_o(dst_mem),
      .src_wb_en_o(src_wb_en), .src_wb_reg_o(src_wb_reg), .src_wb_data_o(src_wb_data),
      .dst_wb_en_o(dst_wb_en), .dst_wb_reg_o(dst_wb_reg), .dst_wb_data_o(dst_wb_data),
      .conflict_o(conflict)
   );

   // register k holds k * 0x1111, so register 15 holds 0xFFFF
   always_comb
      for (int k = 0; k < 16; k++) regs[k*16 +: 16] = 16'(k * 16'h1111);

   typedef struct packed {
      logic [3:0] sm; logic [3:0] sr; logic [3:0] dm; logic [3:0] dr; logic [3:0] ir;
      logic bo; logic [9:0] lt; logic [15:0] fa;
      logic [15:0] sea; logic sme; logic swb;
      logic [15:0] dea; logic dme; logic dwb;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      // R1 src file direct, R3 dst indirect
      '{4'd0, 4'd0, 4'd2, 4'd2, 4'd0, 1'b0, 10'h000, 16'h0800, 16'h0800, 1'b1, 1'b0, 16'h2222, 1'b1, 1'b0},
      // R2 src register direct, R9 dst file direct
      '{4'd1, 4'd3, 4'd0, 4'd0, 4'd0, 1'b0, 10'h000, 16'h1234, 16'h0000, 1'b0, 1'b0, 16'h1234, 1'b1, 1'b0},
      // R7 both indexed by the shared index register 2
      '{4'd7, 4'd1, 4'd7, 4'd4, 4'd2, 1'b0, 10'h000, 16'h0000, 16'h3333, 1'b1, 1'b0, 16'h6666, 1'b1, 1'b0},
      // R8 negative literal on both
      '{4'd8, 4'd5, 4'd8, 4'd15, 4'd0, 1'b0, 10'h3FF, 16'h0000, 16'h5554, 1'b1, 1'b0, 16'hFFFE, 1'b1, 1'b0},
      // R8 positive literal wraps, R3 dst indirect on register 0
      '{4'd8, 4'd15, 4'd2, 4'd0, 4'd0, 1'b0, 10'h002, 16'h0000, 16'h0001, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0},
      // R4 src post-inc, R5 dst pre-dec, word step
      '{4'd3, 4'd6, 4'd6, 4'd7, 4'd0, 1'b0, 10'h000, 16'h0000, 16'h6666, 1'b1, 1'b1, 16'h7775, 1'b1, 1'b1},
      // R5 src pre-inc, R4 dst post-dec, R6 byte step
      '{4'd5, 4'd8, 4'd4, 4'd9, 4'd0, 1'b1, 10'h000, 16'h0000, 16'h8889, 1'b1, 1'b1, 16'h9999, 1'b1, 1'b1},
      // R12 reserved codes on both
      '{4'd12, 4'd1, 4'd15, 4'd2, 4'd0, 1'b0, 10'h000, 16'h4321, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0},
      // R7 index wrap, R2 dst register direct
      '{4'd7, 4'd15, 4'd1, 4'd5, 4'd1, 1'b0, 10'h000, 16'h0000, 16'h1110, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [3:0] sm, input logic [3:0] sr, input logic [3:0] dm,
                        input logic [3:0] dr, input logic [3:0] ir, input logic bo,
                        input logic [9:0] lt, input logic [15:0] fa);
      @(negedge clk);
      in_valid = 1'b1; src_mode = sm; src_reg = sr; dst_mode = dm; dst_reg = dr;
      idx_reg = ir; byte_op = bo; lit = lt; faddr = fa;
      @(negedge clk);   // one register stage: result visible here
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 reset valid", {31'd0, out_valid}, 32'd0);
      chk("R11 reset flags", {28'd0, src_mem, dst_mem, src_wb_en, conflict}, 32'd0);
      chk("R11 reset ea", {src_ea, dst_ea}, 32'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         issue(VECS[i].sm, VECS[i].sr, VECS[i].dm, VECS[i].dr, VECS[i].ir,
               VECS[i].bo, VECS[i].lt, VECS[i].fa);
         chk($sformatf("R9 vec%0d src ea", i), {16'd0, src_ea}, {16'd0, VECS[i].sea});
         chk($sformatf("R9 vec%0d dst ea", i), {16'd0, dst_ea}, {16'd0, VECS[i].dea});
         chk($sformatf("R9 vec%0d flags", i), {28'd0, src_mem, src_wb_en, dst_mem, dst_wb_en},
             {28'd0, VECS[i].sme, VECS[i].swb, VECS[i].dme, VECS[i].dwb});
         chk($sformatf("R11 vec%0d valid", i), {31'd0, out_valid}, 32'd1);
      end

      // R4 R6 word post-inc writeback, R5 pre-dec
      issue(4'd3, 4'd6, 4'd6, 4'd7, 4'd0, 1'b0, 10'h0, 16'h0);
      chk("R4 src wb", {11'd0, src_wb_en, src_wb_reg, src_wb_data}, {11'd0, 1'b1, 4'd6, 16'h6668});
      chk("R5 dst wb", {11'd0, dst_wb_en, dst_wb_reg, dst_wb_data}, {11'd0, 1'b1, 4'd7, 16'h7775});
      chk("R10 no conflict", {31'd0, conflict}, 32'd0);

      // R5 R6 byte pre-dec; R8 post-inc wraps 0xFFFF -> 0x0000
      issue(4'd6, 4'd10, 4'd3, 4'd15, 4'd0, 1'b1, 10'h0, 16'h0);
      chk("R5 byte pre-dec ea", {16'd0, src_ea}, {16'd0, 16'hAAA9});
      chk("R5 byte pre-dec wb", {16'd0, src_wb_data}, {16'd0, 16'hAAA9});
      chk("R8 post-inc wrap ea", {16'd0, dst_ea}, {16'd0, 16'hFFFF});
      chk("R8 post-inc wrap wb", {16'd0, dst_wb_data}, 32'd0);

      // R10 both modify register 3: destination wins
      issue(4'd3, 4'd3, 4'd5, 4'd3, 4'd0, 1'b0, 10'h0, 16'h0);
      chk("R10 conflict flag", {31'd0, conflict}, 32'd1);
      chk("R10 src dropped", {31'd0, src_wb_en}, 32'd0);
      chk("R10 dst kept", {11'd0, dst_wb_en, dst_wb_reg, dst_wb_data}, {11'd0, 1'b1, 4'd3, 16'h3335});
      chk("R10 eas", {src_ea, dst_ea}, {16'h3333, 16'h3335});

      // R10 only destination modifies register 3: no conflict
      issue(4'd2, 4'd3, 4'd3, 4'd3, 4'd0, 1'b0, 10'h0, 16'h0);
      chk("R10 single modifier", {30'd0, conflict, src_wb_en}, 32'd0);
      chk("R3 indirect same reg", {16'd0, src_ea}, {16'd0, 16'h3333});

      // R11 idle cycle
      @(negedge clk); in_valid = 1'b0;
      @(negedge clk);
      chk("R11 idle", {26'd0, out_valid, src_mem, dst_mem, src_wb_en, dst_wb_en, conflict}, 32'd0);

      done = 1'b1;
   end

   initial begin
      for (int t = 0; t < 2000 && !done; t++) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule